// File: doc/BRIEF.md
# Run-Length Zero Codec for Activation Streams

This block shrinks a stream of 16-bit activation values before they cross the 64-bit link to off-chip memory, and restores them on the way back. After a rectifying layer most activations are zero, so the encoder replaces each stretch of zeros with a count. It emits (run, level) pairs, where the run is the number of zeros in front of a value and the level is that value. Three pairs and one end-of-stream flag fill each 64-bit word.

The decoder takes those words and produces the original 16-bit stream one value per cycle, with a last flag on the final value. The two halves are independent and share only clock and reset. A system places the encoder on the write path and the decoder on the read path. Every stream port uses a valid/ready handshake.

Encoder states: `ENC_COLLECT` accepts samples and packs pairs. When a word is full, or the last sample has produced its pair, the encoder moves to `ENC_SEND`. `ENC_SEND` holds the word until the receiver accepts it, then returns to `ENC_COLLECT`.

Decoder states: `DEC_IDLE` accepts a word and enters its first pair. A pair with a non-zero run goes to `DEC_ZEROS`; a pair with run 0 goes to `DEC_LEVEL`. `DEC_ZEROS` counts zeros out. On its last zero it moves to `DEC_LEVEL` if the level is non-zero; otherwise it finishes the pair. Finishing a pair in `DEC_ZEROS` or `DEC_LEVEL` moves to the next filled pair, or back to `DEC_IDLE` once the word is used up.

Top module: `rlz_codec`

## Requirements
- R1: Word layout. Pair k occupies bits [21k+20:21k]. Within a pair, the run sits in the low 5 bits and the level in the 16 bits above it, so pair 0 uses bits [20:0]. Bit 63 is the end-of-stream flag.
- R2: A non-zero sample produces the pair (number of zeros since the previous pair, sample). When the stream continues, the input 0,0,12,0,0,0,0,53,0,0,22 yields the word with pairs (2,12), (4,53), (2,22) and bit 63 at 0.
- R3: A word whose bit 63 is 0 carries three filled pairs. The encoder keeps its output word stable while it is not accepted. It deasserts its input ready while a word is pending.
- R4: When a zero run reaches 31 zeros, the encoder emits the pair (31,0) and starts counting again from 0.
- R5: On the sample flagged last, the encoder closes the word with bit 63 set. If that sample is zero, the pending zeros c (c is at least 1) go out as the pair (c,0). Unfilled pairs in that word are all-zero.
- R6: The decoder expands (r,L) with L non-zero into r zeros followed by L. It expands (r,0) into r zeros and an all-zero pair into nothing.
- R7: The decoder delivers one value per accepted cycle and holds its data and last flag while not accepted. Its input ready is high only when no pair is being expanded.
- R8: The decoder raises its last flag on the final value of a word that has bit 63 set, and on no other value.
- R9: After reset both input readys are high and both output valids are low.
- R10: Decoding the encoder's words gives back exactly the original sequence and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_i_valid | input | 1 | Sample valid |
| enc_i_ready | output | 1 | Encoder accepts a sample |
| enc_i_data | input | 16 | Activation sample |
| enc_i_last | input | 1 | Sample ends the stream |
| enc_o_valid | output | 1 | Packed word valid |
| enc_o_ready | input | 1 | Word receiver ready |
| enc_o_word | output | 64 | Packed word |
| dec_i_valid | input | 1 | Packed word valid |
| dec_i_ready | output | 1 | Decoder accepts a word |
| dec_i_word | input | 64 | Packed word |
| dec_o_valid | output | 1 | Restored value valid |
| dec_o_ready | input | 1 | Value receiver ready |
| dec_o_data | output | 16 | Restored value |
| dec_o_last | output | 1 | Final value of the stream |

## Verification
A packed word becomes valid one cycle after the handshake of the sample that completes it. The decoder's first value becomes valid one cycle after its word is accepted, and each further value follows one cycle after the previous one is accepted. The bench drives inputs on the falling edge and samples outputs 1 ns later. It counts a transfer only when valid and ready are both seen at that point. Every stall is rechecked at the next sampling point for unchanged outputs, so each result is compared in the cycle it is due rather than at a fixed offset.

// File: rtl/rlz_pkg.sv
package rlz_pkg;

    typedef enum logic {
        ENC_COLLECT = 1'b0,
        ENC_SEND    = 1'b1
    } enc_state_e;

    typedef enum logic [1:0] {
        DEC_IDLE  = 2'd0,
        DEC_ZEROS = 2'd1,
        DEC_LEVEL = 2'd2
    } dec_state_e;

endpackage

// File: rtl/rlz_encoder.sv
module rlz_encoder
    import rlz_pkg::*;
#(
    parameter int VAL_W = 16,
    parameter int RUN_W = 5,
    parameter int NPAIR = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              i_valid,
    output logic                              i_ready,
    input  logic [VAL_W-1:0]                  i_data,
    input  logic                              i_last,
    output logic                              o_valid,
    input  logic                              o_ready,
    output logic [NPAIR*(RUN_W+VAL_W):0]      o_word
);
    localparam int PAIR_W = RUN_W + VAL_W;
    localparam int BODY_W = NPAIR * PAIR_W;
    localparam int IDX_W  = (NPAIR > 1) ? $clog2(NPAIR) : 1;
    localparam logic [RUN_W:0] RUN_LIM = (RUN_W+1)'((1 << RUN_W) - 1);

    enc_state_e        state_q, state_d;
    logic [RUN_W-1:0]  run_q, run_d;
    logic [IDX_W-1:0]  slot_q, slot_d;
    logic [BODY_W-1:0] body_q, body_d;
    logic              term_q, term_d;

    logic              take, emit;
    logic [RUN_W:0]    run_inc;
    logic [RUN_W-1:0]  pr_run;
    logic [VAL_W-1:0]  pr_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENC_COLLECT;
            run_q   <= '0;
            slot_q  <= '0;
            body_q  <= '0;
            term_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            slot_q  <= slot_d;
            body_q  <= body_d;
            term_q  <= term_d;
        end
    end

    always_comb begin
        run_inc = {1'b0, run_q} + 1'b1;
        take    = (state_q == ENC_COLLECT) && i_valid;
        emit    = 1'b0;
        pr_run  = run_q;
        pr_lvl  = i_data;
        if (i_data != '0) begin
            emit = 1'b1;
        end else if (run_inc == RUN_LIM || i_last) begin
            emit   = 1'b1;
            pr_run = run_inc[RUN_W-1:0];
            pr_lvl = '0;
        end

        state_d = state_q;
        run_d   = run_q;
        slot_d  = slot_q;
        body_d  = body_q;
        term_d  = term_q;
        unique case (state_q)
            ENC_COLLECT: begin
                if (take) begin
                    if (emit) begin
                        run_d = '0;
                        for (int k = 0; k < NPAIR; k++) begin
                            if (slot_q == IDX_W'(k))
                                body_d[k*PAIR_W +: PAIR_W] = {pr_lvl, pr_run};
                        end
                        if (slot_q == IDX_W'(NPAIR-1) || i_last) begin
                            state_d = ENC_SEND;
                            term_d  = i_last;
                            slot_d  = '0;
                        end else begin
                            slot_d = slot_q + 1'b1;
                        end
                    end else begin
                        run_d = run_inc[RUN_W-1:0];
                    end
                end
            end
            ENC_SEND: begin
                if (o_ready) begin
                    state_d = ENC_COLLECT;
                    body_d  = '0;
                    term_d  = 1'b0;
                end
            end
            default: state_d = ENC_COLLECT;
        endcase
    end

    always_comb begin
        i_ready = (state_q == ENC_COLLECT);
        o_valid = (state_q == ENC_SEND);
        o_word  = {term_q, body_q};
    end

endmodule

// File: rtl/rlz_decoder.sv
module rlz_decoder
    import rlz_pkg::*;
#(
    parameter int VAL_W = 16,
    parameter int RUN_W = 5,
    parameter int NPAIR = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              i_valid,
    output logic                              i_ready,
    input  logic [NPAIR*(RUN_W+VAL_W):0]      i_word,
    output logic                              o_valid,
    input  logic                              o_ready,
    output logic [VAL_W-1:0]                  o_data,
    output logic                              o_last
);
    localparam int PAIR_W = RUN_W + VAL_W;
    localparam int BODY_W = NPAIR * PAIR_W;
    localparam int IDX_W  = (NPAIR > 1) ? $clog2(NPAIR) : 1;

    dec_state_e        state_q, state_d;
    logic [BODY_W-1:0] body_q, body_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [RUN_W-1:0]  rem_q, rem_d;
    logic              term_q, term_d;

    logic [RUN_W-1:0]  run_a  [NPAIR];
    logic [VAL_W-1:0]  lvl_a  [NPAIR];
    logic              tail_a [NPAIR];
    logic [RUN_W-1:0]  nrun_a [NPAIR];

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign run_a[g] = body_q[g*PAIR_W +: RUN_W];
        assign lvl_a[g] = body_q[g*PAIR_W+RUN_W +: VAL_W];
        if (g == NPAIR-1) begin : g_end
            assign tail_a[g] = 1'b1;
            assign nrun_a[g] = '0;
        end else begin : g_mid
            assign tail_a[g] = (body_q[(g+1)*PAIR_W +: PAIR_W] == '0);
            assign nrun_a[g] = body_q[(g+1)*PAIR_W +: RUN_W];
        end
    end

    logic [VAL_W-1:0] cur_lvl;
    logic             pair_last, fin;
    logic [RUN_W-1:0] in_run0, nrun;
    logic [VAL_W-1:0] in_lvl0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DEC_IDLE;
            body_q  <= '0;
            idx_q   <= '0;
            rem_q   <= '0;
            term_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            body_q  <= body_d;
            idx_q   <= idx_d;
            rem_q   <= rem_d;
            term_q  <= term_d;
        end
    end

    always_comb begin
        cur_lvl   = lvl_a[idx_q];
        pair_last = tail_a[idx_q];
        nrun      = nrun_a[idx_q];
        in_run0   = i_word[RUN_W-1:0];
        in_lvl0   = i_word[PAIR_W-1:RUN_W];
        fin = (state_q == DEC_LEVEL) ||
              (state_q == DEC_ZEROS && rem_q == RUN_W'(1) && cur_lvl == '0);

        state_d = state_q;
        body_d  = body_q;
        idx_d   = idx_q;
        rem_d   = rem_q;
        term_d  = term_q;
        unique case (state_q)
            DEC_IDLE: begin
                if (i_valid) begin
                    body_d = i_word[BODY_W-1:0];
                    term_d = i_word[BODY_W];
                    idx_d  = '0;
                    if (in_run0 != '0) begin
                        state_d = DEC_ZEROS;
                        rem_d   = in_run0;
                    end else if (in_lvl0 != '0) begin
                        state_d = DEC_LEVEL;
                    end
                end
            end
            DEC_ZEROS, DEC_LEVEL: begin
                if (o_ready) begin
                    if (fin) begin
                        if (pair_last) begin
                            state_d = DEC_IDLE;
                        end else begin
                            idx_d = idx_q + 1'b1;
                            if (nrun != '0) begin
                                state_d = DEC_ZEROS;
                                rem_d   = nrun;
                            end else begin
                                state_d = DEC_LEVEL;
                            end
                        end
                    end else if (rem_q == RUN_W'(1)) begin
                        state_d = DEC_LEVEL;
                    end else begin
                        rem_d = rem_q - 1'b1;
                    end
                end
            end
            default: state_d = DEC_IDLE;
        endcase
    end

    always_comb begin
        i_ready = (state_q == DEC_IDLE);
        o_valid = (state_q != DEC_IDLE);
        o_data  = (state_q == DEC_LEVEL) ? cur_lvl : '0;
        o_last  = term_q && pair_last && fin;
    end

endmodule

// File: rtl/rlz_codec.sv
module rlz_codec #(
    parameter int VAL_W = 16,
    parameter int RUN_W = 5,
    parameter int NPAIR = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enc_i_valid,
    output logic                          enc_i_ready,
    input  logic [VAL_W-1:0]              enc_i_data,
    input  logic                          enc_i_last,
    output logic                          enc_o_valid,
    input  logic                          enc_o_ready,
    output logic [NPAIR*(RUN_W+VAL_W):0]  enc_o_word,
    input  logic                          dec_i_valid,
    output logic                          dec_i_ready,
    input  logic [NPAIR*(RUN_W+VAL_W):0]  dec_i_word,
    output logic                          dec_o_valid,
    input  logic                          dec_o_ready,
    output logic [VAL_W-1:0]              dec_o_data,
    output logic                          dec_o_last
);

    rlz_encoder #(.VAL_W(VAL_W), .RUN_W(RUN_W), .NPAIR(NPAIR)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_valid (enc_i_valid),
        .i_ready (enc_i_ready),
        .i_data  (enc_i_data),
        .i_last  (enc_i_last),
        .o_valid (enc_o_valid),
        .o_ready (enc_o_ready),
        .o_word  (enc_o_word)
    );

    rlz_decoder #(.VAL_W(VAL_W), .RUN_W(RUN_W), .NPAIR(NPAIR)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_valid (dec_i_valid),
        .i_ready (dec_i_ready),
        .i_word  (dec_i_word),
        .o_valid (dec_o_valid),
        .o_ready (dec_o_ready),
        .o_data  (dec_o_data),
        .o_last  (dec_o_last)
    );

endmodule

// File: rtl/rlz_codec_checker.sv
module rlz_codec_checker #(
    parameter int VAL_W = 16,
    parameter int RUN_W = 5,
    parameter int NPAIR = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          enc_i_valid,
    input logic                          enc_i_ready,
    input logic [VAL_W-1:0]              enc_i_data,
    input logic                          enc_i_last,
    input logic                          enc_o_valid,
    input logic                          enc_o_ready,
    input logic [NPAIR*(RUN_W+VAL_W):0]  enc_o_word,
    input logic                          dec_i_valid,
    input logic                          dec_i_ready,
    input logic [NPAIR*(RUN_W+VAL_W):0]  dec_i_word,
    input logic                          dec_o_valid,
    input logic                          dec_o_ready,
    input logic [VAL_W-1:0]              dec_o_data,
    input logic                          dec_o_last
);
    localparam int PAIR_W = RUN_W + VAL_W;
    localparam int TOP    = NPAIR * PAIR_W;

    a_r3_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        enc_o_valid && !enc_o_ready |=> enc_o_valid && $stable(enc_o_word));

    a_r3_enc_stall: assert property (@(posedge clk) disable iff (!rst_n)
        enc_o_valid |-> !enc_i_ready);

    a_r3_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        enc_o_valid && !enc_o_word[TOP] |-> enc_o_word[(NPAIR-1)*PAIR_W +: PAIR_W] != '0);

    a_r5_pad_tail: assert property (@(posedge clk) disable iff (!rst_n)
        enc_o_valid && enc_o_word[TOP] && enc_o_word[0 +: PAIR_W] == '0
        |-> enc_o_word[TOP-1:0] == '0);

    a_r7_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dec_o_valid && !dec_o_ready |=> dec_o_valid && $stable(dec_o_data) && $stable(dec_o_last));

    a_r7_dec_stall: assert property (@(posedge clk) disable iff (!rst_n)
        dec_o_valid |-> !dec_i_ready);

    a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        dec_o_last |-> dec_o_valid);

endmodule

bind rlz_codec rlz_codec_checker #(.VAL_W(VAL_W), .RUN_W(RUN_W), .NPAIR(NPAIR)) u_chk (.*);

// File: tb/test_rlz_codec.sv
`timescale 1ns/1ps
module test_rlz_codec;
    localparam int VW = 16;
    localparam int RW = 5;
    localparam int NP = 3;
    localparam int WW = NP*(RW+VW)+1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_i_valid = 1'b0, enc_i_last = 1'b0, enc_o_ready = 1'b0;
    logic [VW-1:0] enc_i_data = '0;
    logic enc_i_ready, enc_o_valid;
    logic [WW-1:0] enc_o_word;
    logic dec_i_valid = 1'b0, dec_o_ready = 1'b0;
    logic [WW-1:0] dec_i_word = '0;
    logic dec_i_ready, dec_o_valid, dec_o_last;
    logic [VW-1:0] dec_o_data;

    int checks = 0;
    int errors = 0;
    logic [VW-1:0] src[$];
    logic [WW-1:0] exp_w[$];
    logic [WW-1:0] got_w[$];

    always #10 clk = ~clk;

    rlz_codec #(.VAL_W(VW), .RUN_W(RW), .NPAIR(NP)) i_rlz_codec (.*);

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [RW+VW-1:0] mkpair(input int run, input logic [VW-1:0] lvl);
        return {lvl, RW'(run)};
    endfunction

    // expected words from the pairing and packing rules (R1 R2 R4 R5)
    task automatic model_encode();
        int run = 0;
        int slot = 0;
        logic [WW-1:0] w = '0;
        exp_w.delete();
        for (int i = 0; i < src.size(); i++) begin
            logic lastf = (i == src.size()-1);
            logic emit = 1'b0;
            int pr = 0;
            logic [VW-1:0] lv = '0;
            if (src[i] != '0) begin
                emit = 1'b1; pr = run; lv = src[i]; run = 0;
            end else if (run+1 == 31 || lastf) begin
                emit = 1'b1; pr = run+1; run = 0;
            end else begin
                run++;
            end
            if (emit) begin
                w[slot*(RW+VW) +: (RW+VW)] = mkpair(pr, lv);
                slot++;
                if (slot == NP || lastf) begin
                    w[WW-1] = lastf;
                    exp_w.push_back(w);
                    w = '0;
                    slot = 0;
                end
            end
        end
    endtask

    task automatic run_case(input string tag);
        int idx = 0;
        int n = 0;
        logic done = 1'b0;
        logic hold = 1'b0;
        logic [WW-1:0] held = '0;
        logic dhold = 1'b0;
        logic [VW:0] dheld = '0;
        model_encode();
        got_w.delete();
        while (!done) begin
            @(negedge clk);
            enc_i_valid = (idx < src.size()) && ($urandom % 4 != 0);
            enc_i_data  = (idx < src.size()) ? src[idx] : '0;
            enc_i_last  = (idx == src.size()-1);
            enc_o_ready = ($urandom % 3 != 0);
            #1;
            if (hold) chk(enc_o_valid && enc_o_word == held, "R3 hold", 64'(enc_o_word), 64'(held));
            if (enc_o_valid) chk(!enc_i_ready, "R3 stall", 64'(enc_i_ready), 64'd0);
            hold = enc_o_valid && !enc_o_ready;
            held = enc_o_word;
            if (enc_i_valid && enc_i_ready) idx++;
            if (enc_o_valid && enc_o_ready) begin
                got_w.push_back(enc_o_word);
                if (enc_o_word[WW-1]) done = 1'b1;
            end
        end
        @(negedge clk);
        enc_i_valid = 1'b0;
        enc_o_ready = 1'b0;
        chk(got_w.size() == exp_w.size(), {tag, " R5 word count"}, 64'(got_w.size()), 64'(exp_w.size()));
        for (int i = 0; i < got_w.size() && i < exp_w.size(); i++)
            chk(got_w[i] == exp_w[i], {tag, " R1 word"}, 64'(got_w[i]), 64'(exp_w[i]));

        idx = 0;
        done = 1'b0;
        while (!done) begin
            @(negedge clk);
            dec_i_valid = (idx < exp_w.size()) && ($urandom % 4 != 0);
            dec_i_word  = (idx < exp_w.size()) ? exp_w[idx] : '0;
            dec_o_ready = ($urandom % 3 != 0);
            #1;
            if (dhold) chk(dec_o_valid && {dec_o_last, dec_o_data} == dheld, "R7 hold",
                           64'({dec_o_last, dec_o_data}), 64'(dheld));
            if (dec_o_valid) chk(!dec_i_ready, "R7 stall", 64'(dec_i_ready), 64'd0);
            dhold = dec_o_valid && !dec_o_ready;
            dheld = {dec_o_last, dec_o_data};
            if (dec_i_valid && dec_i_ready) idx++;
            if (dec_o_valid && dec_o_ready) begin
                if (n < src.size())
                    chk(dec_o_data == src[n], {tag, " R6 value"}, 64'(dec_o_data), 64'(src[n]));
                chk(dec_o_last == (n == src.size()-1), {tag, " R8 last"}, 64'(dec_o_last),
                    64'(n == src.size()-1));
                n++;
                if (dec_o_last || n > src.size()) done = 1'b1;
            end
        end
        @(negedge clk);
        dec_i_valid = 1'b0;
        dec_o_ready = 1'b0;
        chk(n == src.size(), {tag, " R10 length"}, 64'(n), 64'(src.size()));
    endtask

    task automatic push_zeros(input int k);
        for (int i = 0; i < k; i++) src.push_back('0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(enc_i_ready == 1'b1, "R9 enc ready", 64'(enc_i_ready), 64'd1);
        chk(enc_o_valid == 1'b0, "R9 enc valid", 64'(enc_o_valid), 64'd0);
        chk(dec_i_ready == 1'b1, "R9 dec ready", 64'(dec_i_ready), 64'd1);
        chk(dec_o_valid == 1'b0, "R9 dec valid", 64'(dec_o_valid), 64'd0);

        // R2 directed sequence followed by one more value that ends the stream
        src = '{16'd0, 16'd0, 16'd12, 16'd0, 16'd0, 16'd0, 16'd0, 16'd53, 16'd0, 16'd0, 16'd22, 16'd7};
        run_case("R2");
        chk(got_w.size() > 0 && got_w[0] == {1'b0, mkpair(2, 16'd22), mkpair(4, 16'd53), mkpair(2, 16'd12)},
            "R2 first word", 64'(got_w.size() > 0 ? got_w[0] : '0),
            64'({1'b0, mkpair(2, 16'd22), mkpair(4, 16'd53), mkpair(2, 16'd12)}));

        // R4: 70 zeros then a value -> (31,0),(31,0),(8,5) with end flag
        src.delete(); push_zeros(70); src.push_back(16'd5);
        run_case("R4");
        chk(got_w.size() == 1 && got_w[0] == {1'b1, mkpair(8, 16'd5), mkpair(31, '0), mkpair(31, '0)},
            "R4 saturation word", 64'(got_w.size() > 0 ? got_w[0] : '0),
            64'({1'b1, mkpair(8, 16'd5), mkpair(31, '0), mkpair(31, '0)}));

        // R5: trailing zeros and padding
        src = '{16'd9, 16'd0, 16'd0, 16'd0};
        run_case("R5");
        chk(got_w.size() == 1 && got_w[0] == {1'b1, 21'd0, mkpair(3, '0), mkpair(0, 16'd9)},
            "R5 trailing word", 64'(got_w.size() > 0 ? got_w[0] : '0),
            64'({1'b1, 21'd0, mkpair(3, '0), mkpair(0, 16'd9)}));

        src = '{16'd0};
        run_case("R5 single zero");
        src.delete(); push_zeros(31);
        run_case("R4 exact 31");
        src.delete(); push_zeros(62); src.push_back(16'hffff);
        run_case("R4 two runs");

        // random streams, mixed density
        for (int c = 0; c < 8; c++) begin
            int len = 1 + ($urandom % 150);
            int zp = (c < 4) ? 75 : 96;
            src.delete();
            for (int i = 0; i < len; i++) begin
                if (($urandom % 100) < zp) src.push_back('0);
                else src.push_back(VW'(1 + ($urandom % 65535)));
            end
            run_case("R10 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule